// File: doc/BRIEF.md
# Prioritized Compute Queue Dispatcher

This block maps compute queue descriptors onto the queue slots of several asynchronous compute engines. Each engine has a fixed number of slots. Descriptors come in through a valid/ready port and wait in an internal pending store. Whenever any slot in any engine is empty and the store holds work, the block places exactly one descriptor per clock into a free slot. It keeps doing so until every slot is busy or the store is empty.

Placement order follows queue priority. The highest priority waiting descriptor goes first, and among equal priorities the one that arrived earliest goes first. A slot chosen for placement is always empty, so work already running in an engine is never displaced. An engine hands a slot back with a release strobe that names the engine and slot, and the slot becomes usable on the following clock. The engines' own work-item dispatch is not part of this block. Each placement is reported on a registered assignment output one cycle after the decision.

Top module: `queue_dispatch`

## Requirements
- R1: After synchronous active-low reset, `asg_valid` is 0, every bit of `slot_busy` is 0 and `enq_ready` is 1.
- R2: While the pending store holds DEPTH (16) descriptors, `enq_ready` is 0 and an offered descriptor is not stored.
- R3: While every slot is busy, no assignment is made and descriptors stay pending.
- R4: In a cycle where the store is non-empty and at least one slot is empty, exactly one descriptor is placed, and `asg_valid` with its engine, slot and queue ID appears on the next cycle.
- R5: The placed descriptor is the one with the highest `enq_prio` value (3 highest, 0 lowest) among those pending.
- R6: Among pending descriptors of equal priority, the earliest accepted one is placed first.
- R7: The engine is chosen by scanning engines in increasing index order, with wrap-around, starting at the engine after the one that received the previous placement; after reset the scan starts at engine 0.
- R8: Within the chosen engine, the lowest-numbered empty slot is used.
- R9: A release strobe for a busy slot makes that slot empty from the next cycle, so it may be placed into on that cycle.
- R10: A release strobe for a slot that is already empty has no effect.
- R11: A busy slot stays busy until it is released; placement never targets a busy slot. `slot_busy` bit index is engine*SLOTS+slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Descriptor offered |
| enq_ready | output | 1 | Pending store can accept a descriptor |
| enq_qid | input | 6 | Queue ID of the offered descriptor |
| enq_prio | input | 2 | Priority of the offered descriptor, 3 highest |
| rel_valid | input | 1 | Slot release strobe |
| rel_eng | input | 2 | Engine index of the released slot |
| rel_slot | input | 1 | Slot index within that engine |
| asg_valid | output | 1 | An assignment was made on the previous cycle |
| asg_eng | output | 2 | Engine that received the queue |
| asg_slot | output | 1 | Slot that received the queue |
| asg_qid | output | 6 | Queue ID placed |
| slot_busy | output | 8 | Occupancy per slot, bit engine*SLOTS+slot |

## Verification
The assertions watch, on every cycle, that the store is never pushed when full nor popped when empty, that at most one slot turns busy per cycle, that nothing is placed while all slots are occupied, that a busy slot holds until released and that a release of a busy slot takes effect on the next cycle. The choice itself cannot be seen by such local properties: whether the right descriptor went first by priority and age, and whether the engine rotation and lowest-slot rule were followed, is shown only by the bench's reference model. That model runs alongside directed fill, back-pressure, drain and release phases and a long pseudo-random sweep.

// File: rtl/qd_pkg.sv
// Package: shared widths and the pending descriptor type for the queue dispatcher.
// Assumes: queue IDs are 6 bits and priorities 2 bits (larger value = more urgent).
package qd_pkg;
    localparam int QID_W  = 6;
    localparam int PRIO_W = 2;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [QID_W-1:0]  qid;
    } qdesc_t;
endpackage

// File: rtl/qd_pend_buf.sv
// Module: pending descriptor store with priority/age selection.
// Entries are kept compacted in arrival order (index 0 oldest). The selected
// entry is the highest priority one; ties go to the lowest index (oldest).
// Assumes: push is only raised when full is low, pop only when nonempty is high.
module qd_pend_buf import qd_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  qdesc_t push_d,
    input  logic   pop,
    output logic   full,
    output logic   nonempty,
    output qdesc_t sel_d
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    qdesc_t            ent [DEPTH];
    qdesc_t            nxt [DEPTH];
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     ncnt;
    logic [IW-1:0]     sel_idx;
    logic [PRIO_W-1:0] best;
    logic              found;

    assign full     = (cnt == CW'(DEPTH));
    assign nonempty = (cnt != '0);
    assign sel_d    = ent[sel_idx];

    // Pick the oldest entry among those of highest priority.
    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        best    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(cnt) && (!found || ent[i].prio > best)) begin
                found   = 1'b1;
                sel_idx = IW'(i);
                best    = ent[i].prio;
            end
        end
    end

    // Next contents: close the gap left by a pop, then append a push.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) nxt[i] = ent[i];
        ncnt = cnt;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(sel_idx)) nxt[i] = ent[i+1];
            end
            ncnt = cnt - CW'(1);
        end
        if (push) begin
            nxt[ncnt[IW-1:0]] = push_d;
            ncnt = ncnt + CW'(1);
        end
    end

    // Register the store contents and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            cnt <= ncnt;
            for (int i = 0; i < DEPTH; i++) ent[i] <= nxt[i];
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);
endmodule

// File: rtl/qd_slot_track.sv
// Module: slot occupancy tracking and free-slot choice.
// Engines are scanned round-robin starting after the last engine that was
// given a queue; inside an engine the lowest empty slot wins.
// Assumes: grant is only raised when any_free is high.
module qd_slot_track #(
    parameter int NUM_ENG = 4,
    parameter int SLOTS   = 2,
    parameter int EW      = 2,
    parameter int SW      = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     grant,
    input  logic                     rel_valid,
    input  logic [EW-1:0]            rel_eng,
    input  logic [SW-1:0]            rel_slot,
    output logic [NUM_ENG*SLOTS-1:0] busy,
    output logic                     any_free,
    output logic [EW-1:0]            pick_eng,
    output logic [SW-1:0]            pick_slot
);
    localparam int NS = NUM_ENG * SLOTS;

    logic [EW-1:0] last_eng;
    logic [NS-1:0] rel_hit;
    logic [NS-1:0] pick_hit;
    logic [NS-1:0] busy_n;

    assign any_free = ~&busy;

    // Round-robin engine scan, lowest empty slot within the engine.
    always_comb begin
        logic hit;
        hit       = 1'b0;
        pick_eng  = '0;
        pick_slot = '0;
        for (int k = 1; k <= NUM_ENG; k++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (!hit && !busy[((int'(last_eng) + k) % NUM_ENG) * SLOTS + s]) begin
                    hit       = 1'b1;
                    pick_eng  = EW'((int'(last_eng) + k) % NUM_ENG);
                    pick_slot = SW'(s);
                end
            end
        end
    end

    // One-hot decode of the release target and of the chosen slot.
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            rel_hit[i]  = (int'(rel_eng) * SLOTS + int'(rel_slot) == i);
            pick_hit[i] = (int'(pick_eng) * SLOTS + int'(pick_slot) == i);
        end
    end

    // Occupancy update: release clears, placement sets (set wins).
    always_comb begin
        busy_n = busy;
        if (rel_valid) busy_n = busy_n & ~rel_hit;
        if (grant)     busy_n = busy_n | pick_hit;
    end

    // Register occupancy and the engine that last received a queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= '0;
            last_eng <= EW'(NUM_ENG - 1);
        end else begin
            busy <= busy_n;
            if (grant) last_eng <= pick_eng;
        end
    end

    for (genvar g = 0; g < NS; g++) begin : g_slot_chk
        p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            busy[g] && !(rel_valid && rel_hit[g]) |=> busy[g]);
        p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rel_valid && rel_hit[g] && !(grant && pick_hit[g]) |=> !busy[g]);
    end
endmodule

// File: rtl/queue_dispatch.sv
// Module: prioritized compute queue dispatcher (top).
// Buffers queue descriptors and places one per cycle into a free engine slot
// while both a free slot and a pending descriptor exist. Placement is
// reported on registered outputs one cycle later.
// Assumes: engines release only slots they hold; NUM_ENG >= 2.
module queue_dispatch import qd_pkg::*; #(
    parameter int NUM_ENG = 4,
    parameter int SLOTS   = 2,
    parameter int DEPTH   = 16,
    localparam int EW = $clog2(NUM_ENG),
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int NS = NUM_ENG * SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [QID_W-1:0]  enq_qid,
    input  logic [PRIO_W-1:0] enq_prio,
    input  logic              rel_valid,
    input  logic [EW-1:0]     rel_eng,
    input  logic [SW-1:0]     rel_slot,
    output logic              asg_valid,
    output logic [EW-1:0]     asg_eng,
    output logic [SW-1:0]     asg_slot,
    output logic [QID_W-1:0]  asg_qid,
    output logic [NS-1:0]     slot_busy
);
    logic          pb_full;
    logic          pb_nonempty;
    qdesc_t        pb_sel;
    qdesc_t        pb_in;
    logic          any_free;
    logic          grant;
    logic [EW-1:0] pick_eng;
    logic [SW-1:0] pick_slot;
    logic          seen;

    assign enq_ready = !pb_full;
    assign pb_in     = '{prio: enq_prio, qid: enq_qid};
    assign grant     = pb_nonempty && any_free;

    qd_pend_buf #(.DEPTH(DEPTH)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (enq_valid && enq_ready),
        .push_d   (pb_in),
        .pop      (grant),
        .full     (pb_full),
        .nonempty (pb_nonempty),
        .sel_d    (pb_sel)
    );

    qd_slot_track #(.NUM_ENG(NUM_ENG), .SLOTS(SLOTS), .EW(EW), .SW(SW)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .rel_valid (rel_valid),
        .rel_eng   (rel_eng),
        .rel_slot  (rel_slot),
        .busy      (slot_busy),
        .any_free  (any_free),
        .pick_eng  (pick_eng),
        .pick_slot (pick_slot)
    );

    // Register the assignment report for the engines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asg_valid <= 1'b0;
            asg_eng   <= '0;
            asg_slot  <= '0;
            asg_qid   <= '0;
            seen      <= 1'b0;
        end else begin
            asg_valid <= grant;
            asg_eng   <= pick_eng;
            asg_slot  <= pick_slot;
            asg_qid   <= pb_sel.qid;
            seen      <= 1'b1;
        end
    end

    p_hold_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !any_free |=> !asg_valid);
    p_one_per_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> $countones(slot_busy & ~$past(slot_busy)) <= 1);
    p_asg_marks_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        asg_valid |-> slot_busy[int'(asg_eng) * SLOTS + int'(asg_slot)]);
endmodule

// File: tb/queue_dispatch_test.sv
// Bench: reference model of the dispatcher run in lock-step with the design.
module queue_dispatch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enq_valid = 1'b0;
    logic       enq_ready;
    logic [5:0] enq_qid = '0;
    logic [1:0] enq_prio = '0;
    logic       rel_valid = 1'b0;
    logic [1:0] rel_eng = '0;
    logic [0:0] rel_slot = '0;
    logic       asg_valid;
    logic [1:0] asg_eng;
    logic [0:0] asg_slot;
    logic [5:0] asg_qid;
    logic [7:0] slot_busy;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    int  mq_qid[$];
    int  mq_pr[$];
    bit  mbusy[8];
    int  mlast = 3;
    bit  ex_v = 0;
    int  ex_e = 0, ex_s = 0, ex_q = 0;
    int  lfsr = 32'h1ACE;

    always #10 clk = ~clk;

    queue_dispatch uut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_qid(enq_qid), .enq_prio(enq_prio),
        .rel_valid(rel_valid), .rel_eng(rel_eng), .rel_slot(rel_slot),
        .asg_valid(asg_valid), .asg_eng(asg_eng), .asg_slot(asg_slot),
        .asg_qid(asg_qid), .slot_busy(slot_busy)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare outputs with the model, drive inputs, advance model and clock.
    task automatic cyc(input bit ev, input int q, input int p,
                       input bit rv, input int re, input int rs, input string tag);
        int mb;
        int best;
        bit ready;
        @(negedge clk);
        mb = 0;
        for (int i = 0; i < 8; i++) if (mbusy[i]) mb |= (1 << i);
        ready = (mq_qid.size() < 16);
        chk(tag, "asg_valid", int'(asg_valid), int'(ex_v));
        if (ex_v) begin
            chk(tag, "asg_eng", int'(asg_eng), ex_e);
            chk(tag, "asg_slot", int'(asg_slot), ex_s);
            chk(tag, "asg_qid", int'(asg_qid), ex_q);
        end
        chk(tag, "slot_busy", int'(slot_busy), mb);
        chk(tag, "enq_ready", int'(enq_ready), int'(ready));
        enq_valid = ev; enq_qid = 6'(q); enq_prio = 2'(p);
        rel_valid = rv; rel_eng = 2'(re); rel_slot = 1'(rs);
        // placement decision from pre-edge state
        ex_v = 0;
        if (mq_qid.size() > 0 && mb != 8'hFF) begin
            best = 0;
            for (int i = 1; i < mq_qid.size(); i++)
                if (mq_pr[i] > mq_pr[best]) best = i;
            for (int k = 1; k <= 4 && !ex_v; k++) begin
                int e = (mlast + k) % 4;
                for (int s = 0; s < 2 && !ex_v; s++)
                    if (!mbusy[e*2+s]) begin
                        ex_v = 1; ex_e = e; ex_s = s;
                    end
            end
            ex_q = mq_qid[best];
            mq_qid.delete(best); mq_pr.delete(best);
        end
        if (rv && mbusy[re*2+rs]) mbusy[re*2+rs] = 0;
        if (ex_v) begin mbusy[ex_e*2+ex_s] = 1; mlast = ex_e; end
        if (ev && ready) begin mq_qid.push_back(q); mq_pr.push_back(p); end
        @(posedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset values
        idle(2, "R1");
        // R4: fill all eight slots, one placement per cycle
        for (int i = 0; i < 8; i++) cyc(1, 1 + i, 0, 0, 0, 0, "R4");
        idle(2, "R7");
        // R3: all busy, descriptors stay pending
        for (int i = 0; i < 16; i++) cyc(1, 10 + i, (i * 3) % 4, 0, 0, 0, "R3");
        // R2: store full, offer refused
        cyc(1, 63, 3, 0, 0, 0, "R2");
        cyc(1, 62, 3, 0, 0, 0, "R2");
        idle(1, "R3");
        // R5: single releases expose highest-priority choice
        for (int i = 0; i < 8; i++) begin
            cyc(0, 0, 0, 1, i % 4, i / 4, "R5");
            idle(2, "R5");
        end
        // R6: remaining equal-priority entries leave in arrival order
        for (int i = 0; i < 8; i++) begin
            cyc(0, 0, 0, 1, (i + 1) % 4, i % 2, "R6");
            idle(1, "R6");
        end
        // R9: with the store empty, releases clear slots
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, i % 4, i / 4, "R9");
        idle(1, "R9");
        // R10: release of an empty slot changes nothing
        cyc(0, 0, 0, 1, 1, 0, "R10");
        cyc(0, 0, 0, 1, 3, 1, "R10");
        idle(2, "R10");
        // R7: rotation continues from the last engine used
        for (int i = 0; i < 5; i++) cyc(1, 40 + i, 1, 0, 0, 0, "R7");
        idle(2, "R7");
        // R8: free slot 1 then slot 0 of one engine, lowest is used first
        cyc(0, 0, 0, 1, 2, 1, "R8");
        cyc(0, 0, 0, 1, 2, 0, "R8");
        cyc(0, 0, 0, 1, 0, 0, "R8");
        for (int i = 0; i < 3; i++) cyc(1, 50 + i, 2, 0, 0, 0, "R8");
        idle(2, "R8");
        // R11: long pseudo-random sweep against the model
        for (int n = 0; n < 3000; n++) begin
            lfsr = (lfsr << 1) ^ (((lfsr >> 31) & 1) ? 32'h04C11DB7 : 0);
            cyc(lfsr[3:1] < 4, lfsr[9:4], lfsr[11:10], lfsr[14:12] < 3,
                lfsr[16:15], lfsr[17], "R11");
        end
        idle(20, "R11");
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule